// File: doc/BRIEF.md
# Packed Lane Compare and Average Unit

This unit takes two 64-bit packed operands and, in one registered step, produces either a lane-wise comparison mask or a lane-wise rounding average. A two-bit operation code picks equality, greater-than or averaging. Compares work on 8-, 16- or 32-bit lanes and can treat lanes as signed or unsigned. Averages work on 8- or 16-bit lanes and can round up.

Each accepted request gives, one clock later, a 64-bit result, a 32-bit flag word and two update strobes. The flag word holds one 4-bit nibble per byte of the operand. A request with a reserved encoding raises a one-cycle error and leaves the result and the flags as they were.

Top module: `pcav_unit`

## Requirements
- R1: Equality compare (op_sel 0) sets each lane of the result to all ones when the two lanes are equal and to all zeros otherwise. Signedness plays no part.
- R2: Greater-than compare (op_sel 1) sets a lane to all ones when the A lane exceeds the B lane. The lanes are compared as two's-complement values when cmp_signed is 1 and as unsigned values when it is 0.
- R3: For compares, lane_sel picks the lane width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits.
- R4: A compare with lane_sel 3 pulses undef_err for one cycle. In that cycle res_valid, data_upd and ctrl_upd stay low, and res_data and res_flags keep their previous values.
- R5: For compares, each lane's N flag is 1 and its Z flag is 0 when the lane is true, and the reverse when it is false. Within the nibble of a lane, N is bit 3 and Z is bit 2. A lane's flags sit in the nibble of its most significant byte, and that byte's nibble is bits 4k+3 down to 4k for byte k.
- R6: Average (op_sel 2) gives, for each lane, (A + B + avg_round) / 2 truncated. The sum is formed without losing its carry, so 0xFF and 0xFF with rounding give 0xFF.
- R7: Averaging uses 16-bit lanes when avg_wide is 1 and 8-bit lanes when it is 0. lane_sel is ignored for averaging.
- R8: For averaging, only the Z flag is written: it is 1 when the result lane is zero. The N flag is 0.
- R9: Every accepted operation raises res_valid, data_upd and ctrl_upd for exactly one cycle, one clock after in_valid.
- R10: All flag bits that the operation does not write are 0. This includes bits 1 and 0 of every nibble and the nibbles of the lower bytes of a wide lane.
- R11: op_sel 3 behaves as a reserved encoding, in the same way as R4.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 equal, 1 greater-than, 2 average, 3 reserved |
| lane_sel | input | 2 | Compare lane width: 0 byte, 1 half, 2 word, 3 reserved |
| cmp_signed | input | 1 | Greater-than uses signed lanes |
| avg_wide | input | 1 | Average uses 16-bit lanes |
| avg_round | input | 1 | Average adds one before halving |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| res_valid | output | 1 | Result and flags were updated this cycle |
| res_data | output | 64 | Packed result |
| res_flags | output | 32 | Per-byte nibble flags |
| data_upd | output | 1 | Main data updated strobe |
| ctrl_upd | output | 1 | Control/flag updated strobe |
| undef_err | output | 1 | Reserved encoding was requested |

## Verification
The hardest case to reach is a reserved request that arrives directly after a valid one. Only that shows whether the registered result and flags really hold. The stimulus therefore places both reserved encodings back to back behind operations whose results are non-zero and distinctive. Signed against unsigned ordering is forced with lane values that straddle the sign bit, such as 0x80 against 0x7F. The carry case of the average is reached with all-ones lanes and rounding on.

// File: rtl/pcav_pkg.sv
package pcav_pkg;
    localparam int DATA_W  = 64;
    localparam int FLAG_W  = DATA_W / 2;
    localparam int BYTES   = DATA_W / 8;

    typedef enum logic [1:0] {
        OP_EQ  = 2'd0,
        OP_GT  = 2'd1,
        OP_AVG = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic              is_cmp;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
    } pcav_state_t;
endpackage

// File: rtl/pcav_cmp.sv
module pcav_cmp #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    width_sel,
    input  logic          use_gt,
    input  logic          is_signed,
    output logic [DW-1:0] mask
);
    logic [DW-1:0] per_w [3];

    for (genvar s = 0; s < 3; s++) begin : g_size
        localparam int W     = 8 << s;
        localparam int LANES = DW / W;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [W-1:0] xa, xb;
            logic         hit;
            // flipping the sign bit turns a signed order into an unsigned one
            assign xa  = a[l*W +: W] ^ {is_signed, {(W-1){1'b0}}};
            assign xb  = b[l*W +: W] ^ {is_signed, {(W-1){1'b0}}};
            assign hit = use_gt ? (xa > xb) : (xa == xb);
            assign per_w[s][l*W +: W] = {W{hit}};
        end
    end

    always_comb begin
        case (width_sel)
            2'd0:    mask = per_w[0];
            2'd1:    mask = per_w[1];
            2'd2:    mask = per_w[2];
            default: mask = '0;
        endcase
    end
endmodule

// File: rtl/pcav_avg.sv
module pcav_avg #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    input  logic          rnd,
    output logic [DW-1:0] avg
);
    logic [DW-1:0] per_w [2];

    for (genvar s = 0; s < 2; s++) begin : g_size
        localparam int W     = 8 << s;
        localparam int LANES = DW / W;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [W:0] sum;
            assign sum = {1'b0, a[l*W +: W]} + {1'b0, b[l*W +: W]} + {{W{1'b0}}, rnd};
            assign per_w[s][l*W +: W] = sum[W:1];
        end
    end

    assign avg = wide ? per_w[1] : per_w[0];
endmodule

// File: rtl/pcav_flags.sv
module pcav_flags #(
    parameter int DW = 64,
    localparam int FW = DW / 2
) (
    input  logic [DW-1:0] res,
    input  logic [1:0]    width_sel,
    input  logic          n_en,
    output logic [FW-1:0] flags
);
    logic [FW-1:0] per_w [3];

    for (genvar s = 0; s < 3; s++) begin : g_size
        localparam int W     = 8 << s;
        localparam int LANES = DW / W;
        localparam int BPL   = W / 8;
        logic [FW-1:0] loc;
        always_comb begin
            loc = '0;
            for (int l = 0; l < LANES; l++) begin
                loc[4*(l*BPL + BPL - 1) + 3] = n_en & res[l*W + W - 1];
                loc[4*(l*BPL + BPL - 1) + 2] = (res[l*W +: W] == '0);
            end
        end
        assign per_w[s] = loc;
    end

    always_comb begin
        case (width_sel)
            2'd0:    flags = per_w[0];
            2'd1:    flags = per_w[1];
            2'd2:    flags = per_w[2];
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/pcav_unit.sv
module pcav_unit
    import pcav_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        lane_sel,
    input  logic              cmp_signed,
    input  logic              avg_wide,
    input  logic              avg_round,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [FLAG_W-1:0] res_flags,
    output logic              data_upd,
    output logic              ctrl_upd,
    output logic              undef_err
);
    pcav_state_t st_d, st_q;

    logic [DATA_W-1:0] cmp_mask, avg_val, res_d;
    logic [FLAG_W-1:0] flg_d;
    logic [1:0]        fwidth_d;
    logic              is_avg, bad_req;

    assign is_avg   = (op_sel == OP_AVG);
    assign bad_req  = (op_sel == OP_RSV) || (!is_avg && lane_sel == 2'd3);
    assign res_d    = is_avg ? avg_val : cmp_mask;
    assign fwidth_d = is_avg ? {1'b0, avg_wide} : lane_sel;

    pcav_cmp #(.DW(DATA_W)) u_cmp (
        .a(src_a), .b(src_b), .width_sel(lane_sel),
        .use_gt(op_sel == OP_GT), .is_signed(cmp_signed), .mask(cmp_mask)
    );

    pcav_avg #(.DW(DATA_W)) u_avg (
        .a(src_a), .b(src_b), .wide(avg_wide), .rnd(avg_round), .avg(avg_val)
    );

    pcav_flags #(.DW(DATA_W)) u_flags (
        .res(res_d), .width_sel(fwidth_d), .n_en(!is_avg), .flags(flg_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (in_valid) begin
            if (bad_req) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld    = 1'b1;
                st_d.is_cmp = !is_avg;
                st_d.res    = res_d;
                st_d.flg    = flg_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign data_upd  = st_q.vld;
    assign ctrl_upd  = st_q.vld;
    assign undef_err = st_q.err;
    assign res_data  = st_q.res;
    assign res_flags = st_q.flg;

    function automatic logic bytes_are_masks(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < BYTES; k++)
            if (v[8*k +: 8] != 8'h00 && v[8*k +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [FLAG_W-1:0] nib_bits(input logic [3:0] pat);
        logic [FLAG_W-1:0] m;
        for (int k = 0; k < BYTES; k++) m[4*k +: 4] = pat;
        return m;
    endfunction

    assert_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> !res_valid && !data_upd && !ctrl_upd);

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> $stable(res_data) && $stable(res_flags));

    assert_cmp_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_q.is_cmp) |-> bytes_are_masks(res_data));

    assert_spare_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_flags & nib_bits(4'b0011)) == '0);

    assert_avg_no_n_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !st_q.is_cmp) |-> (res_flags & nib_bits(4'b1000)) == '0);

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));
endmodule

// File: tb/pcav_unit_bench.sv
`timescale 1ns/1ps
module pcav_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0, lane_sel = 2'd0;
    logic        cmp_signed = 1'b0, avg_wide = 1'b0, avg_round = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        res_valid, data_upd, ctrl_upd, undef_err;
    logic [63:0] res_data;
    logic [31:0] res_flags;

    always #4 clk = ~clk;

    pcav_unit u_pcav_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sel(lane_sel), .cmp_signed(cmp_signed), .avg_wide(avg_wide),
        .avg_round(avg_round), .src_a(src_a), .src_b(src_b),
        .res_valid(res_valid), .res_data(res_data), .res_flags(res_flags),
        .data_upd(data_upd), .ctrl_upd(ctrl_upd), .undef_err(undef_err)
    );

    typedef struct {
        logic        err;
        logic [63:0] res;
        logic [31:0] flg;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0, errors = 0;
    logic [63:0] last_r = '0;
    logic [31:0] last_f = '0;
    bit          live = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic sg,
                         input logic wd, input logic rn, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        exp_t e;
        int   w;
        e.tag = tag;
        e.err = (op == 2'd3) || (op != 2'd2 && sz == 2'd3);
        e.res = last_r;
        e.flg = last_f;
        if (!e.err) begin
            e.res = '0;
            e.flg = '0;
            w = (op == 2'd2) ? (wd ? 16 : 8) : (8 << sz);
            for (int l = 0; l < 64 / w; l++) begin
                logic [63:0] msk, x, y, v, hb;
                int top;
                msk = (64'd1 << w) - 1;
                hb  = 64'd1 << (w - 1);
                x   = (a >> (l * w)) & msk;
                y   = (b >> (l * w)) & msk;
                if (op == 2'd0)      v = (x == y) ? msk : 64'd0;
                else if (op == 2'd1) v = (sg ? ((x ^ hb) > (y ^ hb)) : (x > y)) ? msk : 64'd0;
                else                 v = (x + y + 64'(rn)) >> 1;
                e.res |= v << (l * w);
                top = l * (w / 8) + w / 8 - 1;
                e.flg[4*top+3] = (op != 2'd2) && ((v & hb) != 0);
                e.flg[4*top+2] = (v == 0);
            end
            last_r = e.res;
            last_f = e.flg;
        end
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; lane_sel = sz; cmp_signed = sg;
        avg_wide = wd; avg_round = rn; src_a = a; src_b = b;
        sbq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: results appear after the posedge that follows the request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (live) begin
                if (sbq.size() != 0) begin
                    exp_t e;
                    e = sbq.pop_front();
                    check({e.tag, " undef_err"}, 64'(undef_err), 64'(e.err));
                    check({e.tag, " R9 valid"}, 64'(res_valid), 64'(!e.err));
                    check({e.tag, " R9 upd"}, 64'({data_upd, ctrl_upd}), e.err ? 64'd0 : 64'd3);
                    check({e.tag, " data"}, res_data, e.res);
                    check({e.tag, " flags"}, 64'(res_flags), 64'(e.flg));
                end else begin
                    check("R9 idle strobes", 64'({res_valid, data_upd, ctrl_upd, undef_err}), 64'd0);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R12 reset data", res_data, 64'd0);
        check("R12 reset flags", 64'(res_flags), 64'd0);
        check("R12 reset strobes", 64'({res_valid, data_upd, ctrl_upd, undef_err}), 64'd0);
        live = 1;
        drive(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, "R1 R5 eq byte");
        drive(2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 64'hAAAA_1234_0000_FFFF, 64'hAAAA_1235_0000_FFFE, "R1 R3 R10 eq half");
        drive(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0002, "R1 R3 eq word");
        drive(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 64'h80FF_0001_7F10_2030, 64'h7F00_0102_8010_1F31, "R2 gt unsigned byte");
        drive(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 64'h80FF_0001_7F10_2030, 64'h7F00_0102_8010_1F31, "R2 gt signed byte");
        drive(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 64'h8000_7FFF_FFFF_0005, 64'h7FFF_8000_0000_0004, "R2 R3 gt signed half");
        drive(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0006, "R2 R3 gt unsigned word");
        drive(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, "R4 reserved width");
        drive(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, "R11 reserved op");
        drive(2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 64'hFFFF_0001_0203_0000, 64'hFF01_0001_0405_0000, "R6 R7 R8 avg byte round");
        drive(2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 64'hFFFF_0001_0203_0100, 64'hFF01_0001_0405_0000, "R6 R8 avg byte trunc");
        drive(2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 64'hFFFF_0000_1234_0001, 64'hFFFF_0000_4321_0000, "R6 R7 R10 avg half");
        drive(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 64'h5, 64'h1, "R4 reserved after avg");
        drive(2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, "R2 R5 gt signed word");
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule